// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block serves 32-bit reads on a simple memory-mapped bus by running a complete read sequence on an attached serial flash. For each bus read it lowers the selected chip select and sends a read opcode. It then sends the low 1 to 4 bytes of the bus offset as the address and lets a programmed number of dummy bytes pass. Finally it gathers four data bytes over one, two or four data lines. The serial clock is mode 0: it idles low, outgoing bits change on its falling edge, and incoming bits are taken on its rising edge. One serial clock period is two core clock cycles.

Each chip select has its own packed setup word, which holds the opcode, the address length, the dummy length and the data lane mode. A one-bit switch decides who owns the flash pins. When the switch is clear, the pins carry the command engine's signals unchanged. When it is set, this engine owns them. Reads that cannot be served end at once with an error response.

Top module: `sfl_mmap_rd`

## Requirements
- R1: After reset the switch is clear, `rd_ready_o` is low and the pins follow the command engine inputs.
- R2: While switch bit 0 (configuration index 0) is clear, `sclk_o`, `cs_no`, `io_o` and `io_oe_o` equal `cmd_sclk_i`, `cmd_cs_ni`, `cmd_io_i` and `cmd_io_oe_i`. While the bit is set, those inputs have no effect on the pins.
- R3: The opcode from setup bits 7:0 goes out first, most significant bit first, on `io_o[0]` (single line). Each bit changes on the falling edge of `sclk_o` and is stable at its rising edge.
- R4: The address phase sends (setup bits 9:8) + 1 bytes on `io_o[0]`, most significant byte first. These bytes are the low bytes of `rd_addr_i`.
- R5: The dummy phase lasts 8 serial clocks per byte, as set by setup bits 11:10 (0 to 3). During it the engine drives no data line.
- R6: The data phase uses setup bits 13:12. Value 0 takes one bit per clock on `io_i[1]`. Value 1 takes two bits per clock on `io_i[1:0]`, with bit 1 first in time. Value 3 takes four bits per clock on `io_i[3:0]`, with bit 3 first. Value 2 behaves as value 0. Every byte arrives most significant bit first.
- R7: The first data byte received lands in `rd_data_o[7:0]` and the fourth in `rd_data_o[31:24]`.
- R8: `rd_ready_o` rises for exactly one cycle, 2*(8 + 8*A + 8*D + 32/L) + 1 cycles after the edge that accepts the read. Here A is the address bytes, D the dummy bytes and L the data lanes. At that cycle every chip select is already high again.
- R9: A read made while the switch is clear, or whose offset exceeds MAP_BYTES-4, gets `rd_ready_o` and `rd_err_o` one cycle after it is accepted. Such a read causes no serial clock and no chip select activity.
- R10: Setup word n is written at configuration index n+1. A read with `rd_cs_i` = n uses setup word n and lowers only `cs_no[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDXW | Configuration index: 0 switch, n+1 setup of chip select n |
| cfg_wdata_i | input | 14 | Configuration write data |
| rd_req_i | input | 1 | Bus read request, held until ready |
| rd_cs_i | input | CSW | Chip select of the read |
| rd_addr_i | input | AW | Byte offset of the read |
| rd_ready_o | output | 1 | One-cycle completion pulse |
| rd_err_o | output | 1 | Error response, valid with ready |
| rd_data_o | output | 32 | Read data, valid with ready |
| cmd_sclk_i | input | 1 | Command engine serial clock |
| cmd_cs_ni | input | NCS | Command engine chip selects |
| cmd_io_i | input | 4 | Command engine data outputs |
| cmd_io_oe_i | input | 4 | Command engine data output enables |
| sclk_o | output | 1 | Serial clock pin |
| cs_no | output | NCS | Chip select pins, active low |
| io_o | output | 4 | Data line outputs |
| io_oe_o | output | 4 | Data line output enables |
| io_i | input | 4 | Data line inputs |

## Verification
A served read completes 2*(8 + 8*A + 8*D + 32/L) + 1 cycles after the accepting clock edge, and a refused read completes after one cycle. The bench raises the request between edges and counts the rising edges until it sees `rd_ready_o` at a falling edge. It compares that count with the formula, so one extra or missing register anywhere in the sequence shows up as a miscompare. The behavioural flash model in the bench checks the bit order in time: it takes outgoing bits on rising `sclk_o` and changes `io_i` only on falling `sclk_o`, so captured data is right only if the engine samples on the correct edges.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int unsigned SETUP_W = 14;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_RSV = 2'd2,
    LANE_X4  = 2'd3
  } lane_e;

  typedef struct packed {
    lane_e      lanes;
    logic [1:0] dummy;
    logic [1:0] abytes_m1;
    logic [7:0] opcode;
  } setup_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_FIN, ST_ERR
  } seq_st_e;

  // serial clocks in the data phase, minus one
  function automatic logic [5:0] data_slots_m1(lane_e l);
    case (l)
      LANE_X2: return 6'd15;
      LANE_X4: return 6'd7;
      default: return 6'd31;
    endcase
  endfunction
endpackage

// File: rtl/sfl_cfg_regs.sv
module sfl_cfg_regs
  import sfl_pkg::*;
#(
  parameter int unsigned NCS  = 4,
  parameter int unsigned IDXW = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDXW-1:0]       idx_i,
  input  logic [SETUP_W-1:0]    wdata_i,
  output logic                  mmap_en_o,
  output setup_t [NCS-1:0]      setup_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mmap_en_o <= 1'b0;
    else if (we_i && idx_i == '0)        mmap_en_o <= wdata_i[0];
  end

  for (genvar g = 0; g < NCS; g++) begin : g_setup
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  setup_o[g] <= '0;
      else if (we_i && idx_i == IDXW'(g + 1))       setup_o[g] <= setup_t'(wdata_i);
    end
  end

  AST_SETUP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(setup_o) && $stable(mmap_en_o)); // R10
endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_pkg::*;
#(
  parameter int unsigned NCS       = 4,
  parameter int unsigned CSW       = 2,
  parameter int unsigned AW        = 32,
  parameter int unsigned MAP_BYTES = 32'h0100_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mmap_en_i,
  input  setup_t [NCS-1:0] setup_i,
  input  logic             rd_req_i,
  input  logic [CSW-1:0]   rd_cs_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             rd_ready_o,
  output logic             rd_err_o,
  output logic [31:0]      rd_data_o,
  output logic             sclk_o,
  output logic [NCS-1:0]   cs_no,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);
  localparam logic [AW-1:0] LAST_OK = AW'(MAP_BYTES - 4);

  seq_st_e        st_q;
  logic           ph_q;
  logic [5:0]     slot_q;
  logic [39:0]    tx_q;
  logic [31:0]    rx_q;
  logic [31:0]    rdata_q;
  logic [CSW-1:0] csq;
  setup_t         cur_q;

  logic        active, bad_req, tx_phase;
  setup_t      sel_s;
  logic [31:0] addr32, rx_next;
  logic [4:0]  sh;

  assign active   = st_q inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA};
  assign tx_phase = st_q inside {ST_CMD, ST_ADDR};
  assign bad_req  = !mmap_en_i || ({1'b0, rd_cs_i} >= (CSW+1)'(NCS)) || (rd_addr_i > LAST_OK);
  assign sel_s    = setup_i[rd_cs_i];
  assign addr32   = 32'(rd_addr_i);
  assign sh       = {2'd3 - sel_s.abytes_m1, 3'b000};

  always_comb begin
    case (cur_q.lanes)
      LANE_X2: rx_next = {rx_q[29:0], io_i[1:0]};
      LANE_X4: rx_next = {rx_q[27:0], io_i};
      default: rx_next = {rx_q[30:0], io_i[1]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= 1'b0;
      slot_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      csq     <= '0;
      cur_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (rd_req_i) begin
          if (bad_req) st_q <= ST_ERR;
          else begin
            st_q   <= ST_CMD;
            ph_q   <= 1'b0;
            slot_q <= 6'd7;
            cur_q  <= sel_s;
            csq    <= rd_cs_i;
            tx_q   <= {sel_s.opcode, addr32 << sh};
          end
        end
        ST_FIN, ST_ERR: st_q <= ST_IDLE;
        default: begin
          if (!ph_q) begin
            ph_q <= 1'b1;
            if (st_q == ST_DATA) rx_q <= rx_next;
          end else begin
            ph_q <= 1'b0;
            if (tx_phase) tx_q <= {tx_q[38:0], 1'b0};
            if (slot_q != '0) slot_q <= slot_q - 6'd1;
            else begin
              case (st_q)
                ST_CMD: begin
                  st_q   <= ST_ADDR;
                  slot_q <= {1'b0, cur_q.abytes_m1, 3'b111};
                end
                ST_ADDR: begin
                  if (cur_q.dummy != 2'd0) begin
                    st_q   <= ST_DUMMY;
                    slot_q <= {1'b0, cur_q.dummy - 2'd1, 3'b111};
                  end else begin
                    st_q   <= ST_DATA;
                    slot_q <= data_slots_m1(cur_q.lanes);
                  end
                end
                ST_DUMMY: begin
                  st_q   <= ST_DATA;
                  slot_q <= data_slots_m1(cur_q.lanes);
                end
                default: begin
                  st_q    <= ST_FIN;
                  rdata_q <= {rx_q[7:0], rx_q[15:8], rx_q[23:16], rx_q[31:24]};
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign sclk_o     = ph_q;
  assign io_o       = {3'b000, tx_q[39]};
  assign io_oe_o    = {3'b000, tx_phase};
  assign rd_ready_o = (st_q == ST_FIN) || (st_q == ST_ERR);
  assign rd_err_o   = (st_q == ST_ERR);
  assign rd_data_o  = rdata_q;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_no[g] = !(active && csq == CSW'(g));
  end

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no)); // R10
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no == {NCS{1'b1}}) |-> !sclk_o); // R3
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |=> !rd_ready_o); // R8
  AST_READY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |-> $past(rd_req_i)); // R8
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (cs_no == {NCS{1'b1}}) && !sclk_o && ($past(cs_no) == {NCS{1'b1}})); // R9
endmodule

// File: rtl/sfl_pin_mux.sv
module sfl_pin_mux #(
  parameter int unsigned NCS = 4
) (
  input  logic           own_i,
  input  logic           eng_sclk_i,
  input  logic [NCS-1:0] eng_cs_ni,
  input  logic [3:0]     eng_io_i,
  input  logic [3:0]     eng_oe_i,
  input  logic           cmd_sclk_i,
  input  logic [NCS-1:0] cmd_cs_ni,
  input  logic [3:0]     cmd_io_i,
  input  logic [3:0]     cmd_oe_i,
  output logic           sclk_o,
  output logic [NCS-1:0] cs_no,
  output logic [3:0]     io_o,
  output logic [3:0]     io_oe_o
);
  assign sclk_o  = own_i ? eng_sclk_i : cmd_sclk_i;
  assign cs_no   = own_i ? eng_cs_ni  : cmd_cs_ni;
  assign io_o    = own_i ? eng_io_i   : cmd_io_i;
  assign io_oe_o = own_i ? eng_oe_i   : cmd_oe_i;
endmodule

// File: rtl/sfl_mmap_rd.sv
module sfl_mmap_rd
  import sfl_pkg::*;
#(
  parameter int unsigned NCS       = 4,
  parameter int unsigned AW        = 32,
  parameter int unsigned MAP_BYTES = 32'h0100_0000,
  localparam int unsigned CSW      = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int unsigned IDXW     = $clog2(NCS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDXW-1:0]    cfg_idx_i,
  input  logic [SETUP_W-1:0] cfg_wdata_i,
  input  logic               rd_req_i,
  input  logic [CSW-1:0]     rd_cs_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic               rd_ready_o,
  output logic               rd_err_o,
  output logic [31:0]        rd_data_o,
  input  logic               cmd_sclk_i,
  input  logic [NCS-1:0]     cmd_cs_ni,
  input  logic [3:0]         cmd_io_i,
  input  logic [3:0]         cmd_io_oe_i,
  output logic               sclk_o,
  output logic [NCS-1:0]     cs_no,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe_o,
  input  logic [3:0]         io_i
);
  logic             mmap_en;
  setup_t [NCS-1:0] setup;
  logic             eng_sclk;
  logic [NCS-1:0]   eng_cs_n;
  logic [3:0]       eng_io, eng_oe;

  sfl_cfg_regs #(.NCS(NCS), .IDXW(IDXW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .mmap_en_o(mmap_en), .setup_o(setup)
  );

  sfl_seq #(.NCS(NCS), .CSW(CSW), .AW(AW), .MAP_BYTES(MAP_BYTES)) u_seq (
    .clk_i, .rst_ni,
    .mmap_en_i(mmap_en), .setup_i(setup),
    .rd_req_i, .rd_cs_i, .rd_addr_i, .rd_ready_o, .rd_err_o, .rd_data_o,
    .sclk_o(eng_sclk), .cs_no(eng_cs_n), .io_o(eng_io), .io_oe_o(eng_oe), .io_i
  );

  sfl_pin_mux #(.NCS(NCS)) u_mux (
    .own_i(mmap_en),
    .eng_sclk_i(eng_sclk), .eng_cs_ni(eng_cs_n), .eng_io_i(eng_io), .eng_oe_i(eng_oe),
    .cmd_sclk_i, .cmd_cs_ni, .cmd_io_i, .cmd_oe_i(cmd_io_oe_i),
    .sclk_o, .cs_no, .io_o, .io_oe_o
  );
endmodule

// File: tb/tb_sfl_mmap_rd.sv
module tb_sfl_mmap_rd;
  localparam int unsigned NCS = 4;
  localparam int unsigned MAP = 32'h0100_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [13:0] cfg_wd = '0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_cs = '0;
  logic [31:0] rd_addr = '0;
  logic        rd_ready, rd_err;
  logic [31:0] rd_data;
  logic        cmd_sclk = 1'b0;
  logic [3:0]  cmd_cs_n = 4'hF, cmd_io = '0, cmd_oe = '0;
  logic        sclk;
  logic [3:0]  cs_n, io_o, io_oe;
  logic [3:0]  io_drv = '0;

  int n_chk = 0, n_fail = 0;
  int sclk_rises = 0;
  bit model_on = 1'b0;
  int b_ab [NCS], b_db [NCS], b_md [NCS];
  logic [7:0]  m_op;
  logic [31:0] m_addr;
  int m_cs, m_cnt = 0;

  sfl_mmap_rd #(.NCS(NCS), .AW(32), .MAP_BYTES(MAP)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wd),
    .rd_req_i(rd_req), .rd_cs_i(rd_cs), .rd_addr_i(rd_addr),
    .rd_ready_o(rd_ready), .rd_err_o(rd_err), .rd_data_o(rd_data),
    .cmd_sclk_i(cmd_sclk), .cmd_cs_ni(cmd_cs_n), .cmd_io_i(cmd_io), .cmd_io_oe_i(cmd_oe),
    .sclk_o(sclk), .cs_no(cs_n), .io_o(io_o), .io_oe_o(io_oe), .io_i(io_drv)
  );

  always #5 clk = ~clk;
  always @(posedge sclk) sclk_rises++;

  function automatic logic [7:0] fbyte(logic [31:0] a, int c);
    logic [31:0] t;
    t = a * 32'd29 + 32'(c) * 32'd71 + 32'hA5;
    return t[7:0];
  endfunction

  function automatic int lanes_of(int md);
    return (md == 1) ? 2 : (md == 3) ? 4 : 1;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // behavioural flash
  logic [31:0] mdl_s;
  int mdl_l;
  always begin
    wait (model_on && cs_n != 4'hF);
    m_cs = 0;
    for (int i = 0; i < NCS; i++) if (!cs_n[i]) m_cs = i;
    m_op = '0;
    repeat (8) begin @(posedge sclk); m_op = {m_op[6:0], io_o[0]}; end
    m_addr = '0;
    repeat (8 * b_ab[m_cs]) begin @(posedge sclk); m_addr = {m_addr[30:0], io_o[0]}; end
    repeat (8 * b_db[m_cs]) @(posedge sclk);
    mdl_l = lanes_of(b_md[m_cs]);
    mdl_s = {fbyte(m_addr, m_cs), fbyte(m_addr + 1, m_cs),
             fbyte(m_addr + 2, m_cs), fbyte(m_addr + 3, m_cs)};
    for (int k = 0; k < 32 / mdl_l; k++) begin
      logic [3:0] v;
      if (k != 0) @(posedge sclk);
      @(negedge sclk);
      v = 4'((mdl_s >> (32 - mdl_l * (k + 1))) & ((32'd1 << mdl_l) - 1));
      io_drv = (mdl_l == 1) ? {2'b00, v[0], 1'b0} : v;
    end
    @(posedge sclk);
    wait (cs_n == 4'hF);
    io_drv = '0;
    m_cnt++;
  end

  task automatic cfg_wr(input int idx, input logic [13:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wd = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_read(input int c, input logic [31:0] a, input bit exp_err, input logic [7:0] op);
    int cyc, n0, sc0, ab, lat;
    logic [31:0] am, exp_d;
    @(negedge clk);
    n0 = m_cnt; sc0 = sclk_rises; cyc = 0;
    rd_req = 1'b1; rd_cs = 2'(c); rd_addr = a;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (rd_ready || cyc > 2000) break;
    end
    if (exp_err) begin
      chk("R9 error flag", 32'(rd_err), 32'd1);
      chk("R9 error latency", 32'(cyc), 32'd1);
      chk("R9 no sclk activity", 32'(sclk_rises - sc0), 32'd0);
      chk("R9 no cs activity", 32'(m_cnt - n0), 32'd0);
    end else begin
      ab = b_ab[c];
      am = (ab == 4) ? a : (a & ((32'd1 << (8 * ab)) - 1));
      lat = 2 * (8 + 8 * ab + 8 * b_db[c] + 32 / lanes_of(b_md[c])) + 1;
      exp_d = {fbyte(am + 3, c), fbyte(am + 2, c), fbyte(am + 1, c), fbyte(am, c)};
      chk("R8 ready latency (R5 dummy length)", 32'(cyc), 32'(lat));
      chk("R8 cs high at ready", 32'(cs_n), 32'hF);
      chk("R9 no error", 32'(rd_err), 32'd0);
      chk("R7 R6 data word", rd_data, exp_d);
      chk("R3 opcode", 32'(m_op), 32'(op));
      chk("R4 address", m_addr, am);
      chk("R10 chip select", 32'(m_cs), 32'(c));
    end
    rd_req = 1'b0;
    @(negedge clk);
    chk("R8 ready single cycle", 32'(rd_ready), 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 32'(rd_ready), 32'd0);
    chk("R1 pins follow command engine", {27'd0, sclk, cs_n}, {27'd0, 1'b0, 4'hF});
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < NCS; c++) begin b_ab[c] = 3; b_db[c] = 0; b_md[c] = 0; end
    do_read(0, 32'h100, 1'b1, 8'h00);   // R1: switch clear after reset

    @(negedge clk);
    cmd_sclk = 1'b1; cmd_cs_n = 4'b1011; cmd_io = 4'hA; cmd_oe = 4'h5;
    @(negedge clk);
    chk("R2 passthrough sclk/cs", {27'd0, sclk, cs_n}, {27'd0, 1'b1, 4'b1011});
    chk("R2 passthrough io", {24'd0, io_o, io_oe}, {24'd0, 4'hA, 4'h5});
    cfg_wr(0, 14'd1);
    @(negedge clk);
    chk("R2 command inputs ignored sclk/cs", {27'd0, sclk, cs_n}, {27'd0, 1'b0, 4'hF});
    chk("R2 command inputs ignored io", {24'd0, io_o, io_oe}, 32'd0);
    cmd_sclk = 1'b0; cmd_cs_n = 4'hF; cmd_io = '0; cmd_oe = '0;
    model_on = 1'b1;

    for (int i = 0; i < 64; i++) begin
      int md, ab, db, c;
      logic [7:0] op;
      logic [31:0] a;
      md = i / 16; ab = (i / 4) % 4 + 1; db = i % 4; c = i % NCS;
      op = 8'(8'h0B + i * 3);
      a = (32'h9E37_79B9 * 32'(i + 1)) % (MAP - 3);
      b_ab[c] = ab; b_db[c] = db; b_md[c] = md;
      cfg_wr(c + 1, {2'(md), 2'(db), 2'(ab - 1), op});
      do_read(c, a, 1'b0, op);
    end

    b_ab[2] = 4; b_db[2] = 1; b_md[2] = 3;
    cfg_wr(3, {2'd3, 2'd1, 2'd3, 8'hEB});
    do_read(2, MAP - 4, 1'b0, 8'hEB);   // R9: last word inside window
    do_read(2, MAP - 3, 1'b1, 8'hEB);   // R9: crosses window end
    do_read(2, 32'hFFFF_FFFC, 1'b1, 8'hEB);
    cfg_wr(0, 14'd0);
    do_read(1, 32'h40, 1'b1, 8'h00);    // R9: switch cleared

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule